// File: doc/BRIEF.md
# Digitally controlled square-wave oscillator

This block is the oscillator of an all-digital phase-locked loop. It runs from a fast system clock. It turns an unsigned control word, the digital form of the filtered loop voltage, into a square wave. The wave can feed a phase comparator or an outside frequency divider. Each clock, a phase accumulator adds the step `base + slope * ctrl`. The output is the accumulator's top bit, so the output frequency is `f_clk * step / 2^ACC_W`.

Two configuration values set the range, and each does one job. The base sets the lowest frequency. The slope sets the change in frequency per control step. Raising the base lifts the whole range and leaves the per-step gain unchanged.

A park input stops the oscillator and puts it in a quiet state. The configuration can be rewritten only while the oscillator is parked. A monitor port gives a registered copy of the control word, so the loop can be observed without touching it. An optional pipeline register on the step trades one cycle of control latency for a shorter critical path.

Top module: `dco_square`

## Requirements
- R1: After reset, `osc_out` and `ctrl_mon` are 0, the base holds `BASE_RST` and the slope holds `SLOPE_RST`. With the default parameters these are 64 and 16.
- R2: While running, the phase after the k-th rising clock edge since release equals `k * (base + slope * ctrl) mod 2^ACC_W`. `osc_out` is bit `ACC_W-1` of that phase. The first edge after release adds one full step.
- R3: With the base at 0 and the control word at 0, the phase does not move and `osc_out` stays low.
- R4: A control word of 0 gives the lowest frequency, set by the base alone. A control word of all ones gives the highest frequency, `base + slope * (2^CTRL_W - 1)`.
- R5: The step difference between two control words does not depend on the base.
- R6: A larger slope gives a wider span between the lowest and highest frequency.
- R7: Sampling `park` high clears the phase, so `osc_out` and `ctrl_mon` read 0 one cycle later. After release, oscillation restarts from phase zero.
- R8: While not parked, `ctrl_mon` equals the control word sampled at the previous clock edge.
- R9: A configuration write takes effect only while `park` is high. `cfg_sel` 0 loads the base from the low `BASE_W` bits of `cfg_data`. `cfg_sel` 1 loads the slope from the low `SLOPE_W` bits. A write while running changes nothing.
- R10: When the step is a power of two, `osc_out` is high for exactly half of each period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| park | input | 1 | High stops and clears the oscillator and opens the configuration gate |
| ctrl | input | CTRL_W | Unsigned control word from the loop filter |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the base, 1 selects the slope |
| cfg_data | input | CFG_W | Configuration write data |
| osc_out | output | 1 | Square-wave output |
| ctrl_mon | output | CTRL_W | Registered view of the control word, zero while parked |

## Verification
The bench keeps a phase model for each run and compares `osc_out` with it on every cycle. This catches a design that drops the first step after release, resumes from stale phase, or takes its output from the wrong bit. It checks that a base and control word of zero give a dead output, since a design that adds a hidden minimum step would toggle there.

It counts edges across offset and slope sweeps. A base that scaled with the slope, or a slope that had no effect, would show up in those counts. Configuration writes are made while the oscillator runs, and the unchanged phase must match the model. A design with an ungated write port would go out of step. A power-of-two step checks for an exact half-period high time, which an output taken from a lower phase bit or an off-by-one compare would miss.

// File: rtl/dosc_pkg.sv
package dosc_pkg;

   typedef enum logic {
      SEL_BASE  = 1'b0,
      SEL_SLOPE = 1'b1
   } cfg_sel_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dosc_cfg.sv
module dosc_cfg
   import dosc_pkg::*;
#(
   parameter int unsigned BASE_W    = 12,
   parameter int unsigned SLOPE_W   = 8,
   parameter int unsigned CFG_W     = 12,
   parameter int unsigned BASE_RST  = 64,
   parameter int unsigned SLOPE_RST = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               park,
   input  logic               we,
   input  cfg_sel_e           sel,
   input  logic [CFG_W-1:0]   data,
   output logic [BASE_W-1:0]  base_q,
   output logic [SLOPE_W-1:0] slope_q
);

   logic wr_ok;
   assign wr_ok = park & we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= BASE_W'(BASE_RST);
         slope_q <= SLOPE_W'(SLOPE_RST);
      end else if (wr_ok) begin
         if (sel == SEL_BASE) base_q  <= data[BASE_W-1:0];
         else                 slope_q <= data[SLOPE_W-1:0];
      end
   end

   // R9: settings are frozen while the oscillator runs
   a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !park |=> ($stable(base_q) && $stable(slope_q)));

endmodule

// File: rtl/dosc_step.sv
module dosc_step #(
   parameter int unsigned CTRL_W  = 8,
   parameter int unsigned BASE_W  = 12,
   parameter int unsigned SLOPE_W = 8,
   parameter int unsigned STEP_W  = 17
) (
   input  logic [BASE_W-1:0]  base,
   input  logic [SLOPE_W-1:0] slope,
   input  logic [CTRL_W-1:0]  ctrl,
   output logic [STEP_W-1:0]  step
);

   logic [STEP_W-1:0] span;

   always_comb begin
      span = STEP_W'(slope) * STEP_W'(ctrl);
      step = STEP_W'(base) + span;
   end

   // R4: the step never falls below the base
   always_comb begin
      a_r4_step_floor: assert (step >= STEP_W'(base));
   end

endmodule

// File: rtl/dosc_accum.sv
module dosc_accum #(
   parameter int unsigned ACC_W  = 20,
   parameter int unsigned STEP_W = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              park,
   input  logic [STEP_W-1:0] step,
   output logic              osc_out
);

   logic [ACC_W-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    phase_q <= '0;
      else if (park) phase_q <= '0;
      else           phase_q <= phase_q + ACC_W'(step);
   end

   assign osc_out = phase_q[ACC_W-1];

   // R7: parking clears phase and silences the output
   a_r7_park_clears: assert property (@(posedge clk) disable iff (!rst_n)
      park |=> (phase_q == '0 && !osc_out));

   // R7: release always begins from phase zero
   a_r7_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(park) |-> (phase_q == '0));

   // R3: a zero step leaves the phase where it is
   a_r3_zero_step_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!park && step == '0) |=> $stable(phase_q));

   // R2: a nonzero step always moves the phase
   a_r2_phase_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (!park && step != '0) |=> (phase_q != $past(phase_q)));

endmodule

// File: rtl/dosc_mon.sv
module dosc_mon #(
   parameter int unsigned CTRL_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              park,
   input  logic [CTRL_W-1:0] ctrl,
   output logic [CTRL_W-1:0] mon
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mon <= '0;
      else if (park) mon <= '0;
      else           mon <= ctrl;
   end

   // R8: the monitor trails the control word by one clock
   a_r8_mon_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !park |=> (mon == $past(ctrl)));

   // R7: the monitor is quiet while parked
   a_r7_mon_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      park |=> (mon == '0));

endmodule

// File: rtl/dco_square.sv
module dco_square
   import dosc_pkg::*;
#(
   parameter int unsigned CTRL_W    = 8,
   parameter int unsigned BASE_W    = 12,
   parameter int unsigned SLOPE_W   = 8,
   parameter int unsigned ACC_W     = 20,
   parameter int unsigned BASE_RST  = 64,
   parameter int unsigned SLOPE_RST = 16,
   parameter bit          PIPE_STEP = 1'b0,
   localparam int unsigned CFG_W    = max2(BASE_W, SLOPE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              park,
   input  logic [CTRL_W-1:0] ctrl,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [CFG_W-1:0]  cfg_data,
   output logic              osc_out,
   output logic [CTRL_W-1:0] ctrl_mon
);

   localparam int unsigned STEP_W = max2(BASE_W, SLOPE_W + CTRL_W) + 1;

   // elaboration-time parameter checks
   if (CTRL_W < 1 || BASE_W < 1 || SLOPE_W < 1) begin : g_bad_width
      $error("dco_square: widths must be at least one bit");
   end
   if (STEP_W >= ACC_W) begin : g_bad_acc
      $error("dco_square: ACC_W must exceed the step width");
   end
   if (BASE_RST >= (64'd1 << BASE_W) || SLOPE_RST >= (64'd1 << SLOPE_W)) begin : g_bad_rst
      $error("dco_square: reset settings do not fit their fields");
   end

   logic [BASE_W-1:0]  base_q;
   logic [SLOPE_W-1:0] slope_q;
   logic [STEP_W-1:0]  step_c;
   logic [STEP_W-1:0]  step_use;

   dosc_cfg #(
      .BASE_W   (BASE_W),
      .SLOPE_W  (SLOPE_W),
      .CFG_W    (CFG_W),
      .BASE_RST (BASE_RST),
      .SLOPE_RST(SLOPE_RST)
   ) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .park   (park),
      .we     (cfg_we),
      .sel    (cfg_sel_e'(cfg_sel)),
      .data   (cfg_data),
      .base_q (base_q),
      .slope_q(slope_q)
   );

   dosc_step #(
      .CTRL_W (CTRL_W),
      .BASE_W (BASE_W),
      .SLOPE_W(SLOPE_W),
      .STEP_W (STEP_W)
   ) u_step (
      .base (base_q),
      .slope(slope_q),
      .ctrl (ctrl),
      .step (step_c)
   );

   if (PIPE_STEP) begin : g_step_reg
      logic [STEP_W-1:0] step_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) step_q <= '0;
         else        step_q <= step_c;
      end
      assign step_use = step_q;
   end else begin : g_step_direct
      assign step_use = step_c;
   end

   dosc_accum #(
      .ACC_W (ACC_W),
      .STEP_W(STEP_W)
   ) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .park   (park),
      .step   (step_use),
      .osc_out(osc_out)
   );

   dosc_mon #(
      .CTRL_W(CTRL_W)
   ) u_mon (
      .clk  (clk),
      .rst_n(rst_n),
      .park (park),
      .ctrl (ctrl),
      .mon  (ctrl_mon)
   );

endmodule

// File: tb/test_dco_square.sv
module test_dco_square;

   localparam int CTRL_W = 8;
   localparam int ACC_W  = 20;
   localparam int CFG_W  = 12;
   localparam longint MOD  = 64'd1 << ACC_W;
   localparam longint HALF = 64'd1 << (ACC_W - 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              park = 1'b1;
   logic [CTRL_W-1:0] ctrl = '0;
   logic              cfg_we = 1'b0;
   logic              cfg_sel = 1'b0;
   logic [CFG_W-1:0]  cfg_data = '0;
   logic              osc_out;
   logic [CTRL_W-1:0] ctrl_mon;

   int checks = 0;
   int errors = 0;
   longint cur_base  = 64;
   longint cur_slope = 16;

   always #10 clk = ~clk;   // 50 MHz

   dco_square i_dco_square (
      .clk(clk), .rst_n(rst_n), .park(park), .ctrl(ctrl),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
      .osc_out(osc_out), .ctrl_mon(ctrl_mon)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic do_park();
      @(negedge clk);
      park = 1'b1;
      cfg_we = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   // R9: sel 0 = base, 1 = slope; written while parked
   task automatic write_cfg(input bit sel, input int val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_data = CFG_W'(val);
      @(negedge clk);
      cfg_we = 1'b0;
      if (sel) cur_slope = val; else cur_base = val;
   endtask

   function automatic longint rise_count(input longint total);
      if (total < HALF) return 0;
      return (total - HALF) / MOD + 1;
   endfunction

   // releases park, runs n cycles against the phase model (R2)
   task automatic run_model(input int c, input int n, input bit poke, input string req,
                            output longint edges, output longint highs);
      longint step, m;
      int mism, monbad;
      bit prev;
      step = cur_base + cur_slope * c;
      m = 0; mism = 0; monbad = 0; edges = 0; highs = 0; prev = 1'b0;
      @(negedge clk);
      ctrl = CTRL_W'(c);
      park = 1'b0;
      if (poke) begin cfg_we = 1'b1; cfg_sel = 1'b1; cfg_data = 12'd255; end
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         m = (m + step) % MOD;
         if (osc_out !== m[ACC_W-1]) mism++;
         if (ctrl_mon !== CTRL_W'(c)) monbad++;
         if (osc_out && !prev) edges++;
         if (osc_out) highs++;
         prev = osc_out;
         if (poke) begin cfg_sel = ~cfg_sel; cfg_data = cfg_data ^ 12'h5A5; end
      end
      cfg_we = 1'b0;
      chk(mism == 0, {req, " phase model (R2)"}, mism, 0);
      chk(monbad == 0, {req, " monitor (R8)"}, monbad, 0);
      chk(edges == rise_count(longint'(n) * step), {req, " edge count"}, edges, rise_count(longint'(n) * step));
   endtask

   task automatic t_reset();
      longint e, h;
      @(negedge clk);
      chk(osc_out == 1'b0, "R1 osc_out at reset", osc_out, 0);
      chk(ctrl_mon == '0, "R1 ctrl_mon at reset", ctrl_mon, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      run_model(10, 4096, 1'b0, "R1 default settings", e, h);
      do_park();
   endtask

   task automatic t_zero();
      longint e, h;
      write_cfg(1'b0, 0);
      write_cfg(1'b1, 200);
      run_model(0, 2000, 1'b0, "R3 zero", e, h);
      chk(h == 0, "R3 no high cycles", h, 0);
      do_park();
   endtask

   task automatic t_minmax();
      longint elo, ehi, h;
      write_cfg(1'b0, 500);
      write_cfg(1'b1, 100);
      run_model(0, 8192, 1'b0, "R4 min", elo, h);
      do_park();
      run_model(255, 8192, 1'b0, "R4 max", ehi, h);
      chk(ehi == rise_count(8192 * (500 + 100 * 255)), "R4 max frequency", ehi,
          rise_count(8192 * (500 + 100 * 255)));
      do_park();
   endtask

   task automatic t_offset();
      longint a0, a1, b0, b1, h;
      write_cfg(1'b1, 50);
      write_cfg(1'b0, 0);
      run_model(40, 8192, 1'b0, "R5 base0 c40", a0, h); do_park();
      run_model(80, 8192, 1'b0, "R5 base0 c80", a1, h); do_park();
      write_cfg(1'b0, 2000);
      run_model(40, 8192, 1'b0, "R5 base2000 c40", b0, h); do_park();
      run_model(80, 8192, 1'b0, "R5 base2000 c80", b1, h); do_park();
      chk((a1 - a0) - (b1 - b0) <= 1 && (b1 - b0) - (a1 - a0) <= 1,
          "R5 per-step gain unchanged by base", b1 - b0, a1 - a0);
   endtask

   task automatic t_gain();
      longint lo, hi, h;
      write_cfg(1'b0, 100);
      write_cfg(1'b1, 20);
      run_model(255, 8192, 1'b0, "R6 slope20", lo, h); do_park();
      write_cfg(1'b1, 80);
      run_model(255, 8192, 1'b0, "R6 slope80", hi, h); do_park();
      chk(hi > lo, "R6 wider span with larger slope", hi, lo + 1);
   endtask

   task automatic t_inhibit();
      longint e, h;
      int bad;
      write_cfg(1'b0, 3000);
      write_cfg(1'b1, 40);
      run_model(200, 300, 1'b0, "R7 before park", e, h);
      @(negedge clk);
      park = 1'b1;
      bad = 0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (osc_out !== 1'b0 || ctrl_mon !== '0) bad++;
      end
      chk(bad == 0, "R7 quiet while parked", bad, 0);
      run_model(200, 4096, 1'b0, "R7 restart from zero", e, h);
      do_park();
   endtask

   task automatic t_monitor();
      int bad = 0;
      @(negedge clk);
      park = 1'b0;
      for (int k = 0; k < 64; k++) begin
         ctrl = CTRL_W'(k * 37 + 5);
         @(negedge clk);
         if (ctrl_mon !== CTRL_W'(k * 37 + 5)) bad++;
      end
      chk(bad == 0, "R8 monitor tracks changing control", bad, 0);
      do_park();
   endtask

   task automatic t_cfg_gate();
      longint e, h;
      write_cfg(1'b0, 700);
      write_cfg(1'b1, 30);
      run_model(90, 4096, 1'b1, "R9 writes ignored while running", e, h);
      do_park();
      write_cfg(1'b1, 60);
      run_model(90, 4096, 1'b0, "R9 parked write applied", e, h);
      do_park();
   endtask

   task automatic t_duty();
      longint e, h;
      write_cfg(1'b0, 256);
      write_cfg(1'b1, 0);
      run_model(77, 8192, 1'b0, "R10 duty", e, h);
      chk(h == 4096, "R10 half of cycles high", h, 4096);
      chk(e == 2, "R10 two periods", e, 2);
      do_park();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_zero();
      t_minmax();
      t_offset();
      t_gain();
      t_inhibit();
      t_monitor();
      t_cfg_gate();
      t_duty();
      finish_run();
   end

endmodule